// File: doc/BRIEF.md
# VLIW Packet Write Commit Queue

This block holds the architectural side effects produced by the instructions of one very long instruction word packet. It commits them together once the whole packet has executed. Each queued entry records four things: the address of the instruction that produced it, an entry kind, a force flag and a destination with its value. Register and memory results leave the block through one write port. A PC-changing entry updates the next-PC choice instead of the write port.

When a packet begins, the surrounding core pulses a start strobe. The block then empties the queue, latches the current PC, and clears the pending imprecise-exception record and the two non-excepting flags.

A commit strobe starts the commit walk. The walk presents one entry per cycle, in the order the entries were queued. Only the first PC-changing entry counts. Entries belonging to an instruction that raised an imprecise exception may be held back. Which ones are held back depends on the exception class, the exception mask and the force flag of each entry. When a jump-and-link or call has asked for it, the link register is written with the latched packet PC.

Top module: `vliw_commit_queue`

## Requirements
- R1: A `pkt_start` pulse while idle empties the queue, clears `ne_flags` and any pending exception record, and loads `cur_pc` as the packet PC, which `pc_out` shows from the next cycle.
- R2: After `commit`, each entry that is kept and is an ordinary write appears on `wr_en`/`wr_dest`/`wr_data` for one cycle. Entries appear one per cycle, in the order they were queued.
- R3: While an entry's write is presented, and for every kept PC entry, `pc_out` equals that entry's instruction address.
- R4: Kind codes are 0 and 3 for an ordinary write, 1 for a PC write and 2 for a function-style PC write. A PC entry's value is its data field. PC entries never drive `wr_en`. Only the first kept PC entry of either kind in a commit is honoured, and later ones are dropped.
- R5: Commit ends with a one-cycle `done`. At that moment `next_pc` and `pc_out` both hold the honoured PC value, or the packet PC if no PC entry was honoured.
- R6: While an exception record is pending, entries whose address differs from the faulting address are applied normally.
- R7: For a matching entry under a floating-point exception (`exc_fp`=1), the entry is applied only if `exc_mask` has no bit set outside bit 0 (inexact), bit 1 (overflow) and bit 2 (underflow).
- R8: For a matching entry under any other exception kind, the entry is applied only if its force flag is set.
- R9: If `link_req` was seen since the last commit, `lr_we` pulses with `done` and `lr_data` equals the packet PC. The link flag is then cleared, so the following commit does not write the link register.
- R10: After a commit the queue is empty. An immediate second commit presents no writes and returns the packet PC.
- R11: Queuing into a full queue (DEPTH entries) drops the entry and pulses `overflow` for one cycle. The entries already held are still committed.
- R12: After reset, `busy`, `wr_en`, `done`, `overflow` and `ne_flags` are 0, and `pc_out` and `next_pc` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_start | input | 1 | Start of a new packet |
| cur_pc | input | AW | PC of the packet being started |
| enq_valid | input | 1 | Queue one entry |
| enq_addr | input | AW | Address of the queuing instruction |
| enq_kind | input | 2 | Entry kind code |
| enq_force | input | 1 | Force-write flag |
| enq_dest | input | DW | Write destination |
| enq_data | input | XW | Write value or PC target |
| ne_set | input | 2 | Sets non-excepting flags |
| exc_set | input | 1 | Record an imprecise exception |
| exc_addr | input | AW | Faulting instruction address |
| exc_fp | input | 1 | Exception is floating-point class |
| exc_mask | input | MW | Floating-point exception mask |
| link_req | input | 1 | Request link-register update |
| commit | input | 1 | Start committing the queue |
| busy | output | 1 | Commit in progress |
| overflow | output | 1 | Entry dropped on full queue |
| wr_en | output | 1 | Write port enable |
| wr_dest | output | DW | Write port destination |
| wr_data | output | XW | Write port value |
| pc_out | output | AW | Reported PC |
| done | output | 1 | Commit finished |
| next_pc | output | AW | Resolved next PC |
| lr_we | output | 1 | Link register write |
| lr_data | output | AW | Link register value |
| ne_flags | output | 2 | Non-excepting flags |

## Verification
The main sweep commits a three-entry packet. It runs through every combination of the three entry kinds, every pattern of force flags, and four exception settings: none, a benign floating-point mask, a floating-point mask with an extra bit, and a non-floating exception. Two entries share the faulting address and one does not. The kind patterns separate the first-PC-entry rule from plain ordering. The exception settings separate the mask test from the force test and show that unrelated entries are left alone. Directed packets cover a full queue plus one extra entry, back-to-back commits, the link update and its clearing, and a packet start that discards stale entries and a stale exception record.

// File: rtl/vcq_pkg.sv
package vcq_pkg;
  typedef enum logic [1:0] {
    K_REG  = 2'd0,
    K_PC   = 2'd1,
    K_FNPC = 2'd2,
    K_REGB = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_RUN   = 2'd1,
    S_FINAL = 2'd2
  } state_e;

  function automatic logic is_pc_kind(input logic [1:0] k);
    return (k == K_PC) || (k == K_FNPC);
  endfunction
endpackage

// File: rtl/vcq_store.sv
module vcq_store #(
  parameter int DEPTH = 16,
  parameter int W     = 72,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/vcq_filter.sv
module vcq_filter #(
  parameter int AW = 32,
  parameter int MW = 6,
  parameter logic [MW-1:0] BENIGN = MW'(7)
) (
  input  logic          pend,
  input  logic          fp,
  input  logic [AW-1:0] fault_addr,
  input  logic [MW-1:0] mask,
  input  logic [AW-1:0] ent_addr,
  input  logic          ent_force,
  output logic          keep
);
  logic hit;
  logic mask_ok;

  always_comb begin
    hit     = pend && (ent_addr == fault_addr);
    mask_ok = (mask & ~BENIGN) == '0;
    if (!hit)    keep = 1'b1;
    else if (fp) keep = mask_ok;
    else         keep = ent_force;
  end
endmodule

// File: rtl/vliw_commit_queue.sv
module vliw_commit_queue
  import vcq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int XW    = 32,
  parameter int DW    = 6,
  parameter int MW    = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pkt_start,
  input  logic [AW-1:0] cur_pc,
  input  logic          enq_valid,
  input  logic [AW-1:0] enq_addr,
  input  logic [1:0]    enq_kind,
  input  logic          enq_force,
  input  logic [DW-1:0] enq_dest,
  input  logic [XW-1:0] enq_data,
  input  logic [1:0]    ne_set,
  input  logic          exc_set,
  input  logic [AW-1:0] exc_addr,
  input  logic          exc_fp,
  input  logic [MW-1:0] exc_mask,
  input  logic          link_req,
  input  logic          commit,
  output logic          busy,
  output logic          overflow,
  output logic          wr_en,
  output logic [DW-1:0] wr_dest,
  output logic [XW-1:0] wr_data,
  output logic [AW-1:0] pc_out,
  output logic          done,
  output logic [AW-1:0] next_pc,
  output logic          lr_we,
  output logic [AW-1:0] lr_data,
  output logic [1:0]    ne_flags
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = AW + 2 + 1 + DW + XW;
  localparam logic [MW-1:0] BENIGN_MASK = MW'(7);

  state_e        state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] idx;
  logic [AW-1:0] pkt_pc;
  logic [AW-1:0] npc;
  logic          taken;
  logic          link_f;
  logic          exc_pend;
  logic [AW-1:0] exc_addr_q;
  logic          exc_fp_q;
  logic [MW-1:0] exc_mask_q;

  logic          st_we;
  logic [IW-1:0] st_raddr;
  logic [EW-1:0] st_wdata;
  logic [EW-1:0] st_rdata;

  logic [AW-1:0] e_addr;
  logic [1:0]    e_kind;
  logic          e_force;
  logic [DW-1:0] e_dest;
  logic [XW-1:0] e_data;
  logic          e_keep;
  logic          e_last;
  logic [CW-1:0] idx_nxt;

  assign busy     = (state != S_IDLE);
  assign idx_nxt  = idx + CW'(1);
  assign e_last   = (idx_nxt == cnt);
  assign st_we    = (state == S_IDLE) && !pkt_start && !commit && enq_valid
                    && (cnt != CW'(DEPTH));
  assign st_wdata = {enq_addr, enq_kind, enq_force, enq_dest, enq_data};
  assign st_raddr = (state == S_IDLE) ? '0 : idx_nxt[IW-1:0];
  assign {e_addr, e_kind, e_force, e_dest, e_data} = st_rdata;

  vcq_store #(.DEPTH(DEPTH), .W(EW)) u_store (
    .clk   (clk),
    .we    (st_we),
    .waddr (cnt[IW-1:0]),
    .wdata (st_wdata),
    .raddr (st_raddr),
    .rdata (st_rdata)
  );

  vcq_filter #(.AW(AW), .MW(MW), .BENIGN(BENIGN_MASK)) u_filter (
    .pend       (exc_pend),
    .fp         (exc_fp_q),
    .fault_addr (exc_addr_q),
    .mask       (exc_mask_q),
    .ent_addr   (e_addr),
    .ent_force  (e_force),
    .keep       (e_keep)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      cnt        <= '0;
      idx        <= '0;
      pkt_pc     <= '0;
      npc        <= '0;
      taken      <= 1'b0;
      link_f     <= 1'b0;
      exc_pend   <= 1'b0;
      exc_addr_q <= '0;
      exc_fp_q   <= 1'b0;
      exc_mask_q <= '0;
      ne_flags   <= '0;
      overflow   <= 1'b0;
      wr_en      <= 1'b0;
      wr_dest    <= '0;
      wr_data    <= '0;
      pc_out     <= '0;
      done       <= 1'b0;
      next_pc    <= '0;
      lr_we      <= 1'b0;
      lr_data    <= '0;
    end else begin
      wr_en    <= 1'b0;
      done     <= 1'b0;
      lr_we    <= 1'b0;
      overflow <= 1'b0;
      if (link_req) link_f <= 1'b1;
      case (state)
        S_IDLE: begin
          if (pkt_start) begin
            cnt      <= '0;
            pkt_pc   <= cur_pc;
            pc_out   <= cur_pc;
            ne_flags <= '0;
            exc_pend <= 1'b0;
          end else begin
            ne_flags <= ne_flags | ne_set;
            if (exc_set) begin
              exc_pend   <= 1'b1;
              exc_addr_q <= exc_addr;
              exc_fp_q   <= exc_fp;
              exc_mask_q <= exc_mask;
            end
            if (commit) begin
              idx   <= '0;
              taken <= 1'b0;
              npc   <= pkt_pc;
              state <= (cnt == '0) ? S_FINAL : S_RUN;
            end else if (enq_valid) begin
              if (cnt == CW'(DEPTH)) overflow <= 1'b1;
              else                   cnt <= cnt + CW'(1);
            end
          end
        end
        S_RUN: begin
          if (e_keep) begin
            if (is_pc_kind(e_kind)) begin
              if (!taken) begin
                taken  <= 1'b1;
                npc    <= e_data[AW-1:0];
                pc_out <= e_addr;
              end
            end else begin
              wr_en   <= 1'b1;
              wr_dest <= e_dest;
              wr_data <= e_data;
              pc_out  <= e_addr;
            end
          end
          idx <= idx_nxt;
          if (e_last) state <= S_FINAL;
        end
        default: begin
          next_pc <= npc;
          pc_out  <= npc;
          done    <= 1'b1;
          cnt     <= '0;
          state   <= S_IDLE;
          if (link_f) begin
            lr_we   <= 1'b1;
            lr_data <= pkt_pc;
            link_f  <= 1'b0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/vcq_checker.sv
module vcq_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          pkt_start,
  input logic          enq_valid,
  input logic          busy,
  input logic          overflow,
  input logic          wr_en,
  input logic          done,
  input logic          lr_we,
  input logic [AW-1:0] lr_data,
  input logic [1:0]    ne_flags
);
  a_r1_start_clears_flags: assert property (@(posedge clk) disable iff (rst)
    $past(pkt_start && !busy) |-> (ne_flags == 2'b00));

  a_r2_write_only_in_commit: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> busy);

  a_r5_done_single_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r5_done_when_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r9_link_with_done: assert property (@(posedge clk) disable iff (rst)
    lr_we |-> done);

  a_r11_overflow_cause: assert property (@(posedge clk) disable iff (rst)
    overflow |-> ($past(enq_valid) && !$past(busy)));
endmodule

bind vliw_commit_queue vcq_checker #(.AW(AW)) u_vcq_checker (
  .clk       (clk),
  .rst       (rst),
  .pkt_start (pkt_start),
  .enq_valid (enq_valid),
  .busy      (busy),
  .overflow  (overflow),
  .wr_en     (wr_en),
  .done      (done),
  .lr_we     (lr_we),
  .lr_data   (lr_data),
  .ne_flags  (ne_flags)
);

// File: tb/vliw_commit_queue_tb.sv
module vliw_commit_queue_tb;
  localparam int AW = 32, XW = 32, DW = 6, MW = 6, DEPTH = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pkt_start = 0, enq_valid = 0, enq_force = 0, exc_set = 0, exc_fp = 0;
  logic link_req = 0, commit = 0;
  logic [AW-1:0] cur_pc = '0, enq_addr = '0, exc_addr = '0;
  logic [1:0]    enq_kind = '0, ne_set = '0;
  logic [DW-1:0] enq_dest = '0;
  logic [XW-1:0] enq_data = '0;
  logic [MW-1:0] exc_mask = '0;
  logic busy, overflow, wr_en, done, lr_we;
  logic [DW-1:0] wr_dest;
  logic [XW-1:0] wr_data;
  logic [AW-1:0] pc_out, next_pc, lr_data;
  logic [1:0]    ne_flags;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  vliw_commit_queue #(.DEPTH(DEPTH), .AW(AW), .XW(XW), .DW(DW), .MW(MW)) u_dut (
    .clk(clk), .rst(rst), .pkt_start(pkt_start), .cur_pc(cur_pc),
    .enq_valid(enq_valid), .enq_addr(enq_addr), .enq_kind(enq_kind),
    .enq_force(enq_force), .enq_dest(enq_dest), .enq_data(enq_data),
    .ne_set(ne_set), .exc_set(exc_set), .exc_addr(exc_addr), .exc_fp(exc_fp),
    .exc_mask(exc_mask), .link_req(link_req), .commit(commit), .busy(busy),
    .overflow(overflow), .wr_en(wr_en), .wr_dest(wr_dest), .wr_data(wr_data),
    .pc_out(pc_out), .done(done), .next_pc(next_pc), .lr_we(lr_we),
    .lr_data(lr_data), .ne_flags(ne_flags)
  );

  // observed commit results
  int            nw;
  logic [DW-1:0] o_dest [0:31];
  logic [XW-1:0] o_data [0:31];
  logic [AW-1:0] o_pc   [0:31];
  logic [AW-1:0] o_npc, o_pcout, o_lrd;
  logic          o_lrwe, o_done;

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_pkt(input logic [AW-1:0] pc);
    @(negedge clk); pkt_start = 1; cur_pc = pc;
    @(negedge clk); pkt_start = 0;
  endtask

  task automatic enq(input logic [AW-1:0] a, input logic [1:0] k, input logic f,
                     input logic [DW-1:0] d, input logic [XW-1:0] v);
    @(negedge clk);
    enq_valid = 1; enq_addr = a; enq_kind = k; enq_force = f; enq_dest = d; enq_data = v;
    @(negedge clk); enq_valid = 0;
  endtask

  task automatic set_exc(input logic [AW-1:0] a, input logic fp, input logic [MW-1:0] m);
    @(negedge clk); exc_set = 1; exc_addr = a; exc_fp = fp; exc_mask = m;
    @(negedge clk); exc_set = 0;
  endtask

  task automatic run_commit();
    nw = 0; o_done = 0; o_lrwe = 0;
    @(negedge clk); commit = 1;
    @(negedge clk); commit = 0;
    for (int c = 0; c < 100; c++) begin
      if (wr_en && nw < 32) begin
        o_dest[nw] = wr_dest; o_data[nw] = wr_data; o_pc[nw] = pc_out; nw++;
      end
      if (done) begin
        o_done = 1; o_npc = next_pc; o_pcout = pc_out; o_lrwe = lr_we; o_lrd = lr_data;
        break;
      end
      @(negedge clk);
    end
    check(o_done, "R5 done", 64'(o_done), 64'd1);
    @(negedge clk);
  endtask

  // expected model of the sweep
  logic [AW-1:0] xa [0:2];
  logic [1:0]    xk [0:2];
  logic          xf [0:2];
  logic [XW-1:0] xv [0:2];
  int            en;
  logic [DW-1:0] e_dest [0:2];
  logic [XW-1:0] e_data [0:2];
  logic [AW-1:0] e_pc   [0:2];
  logic [AW-1:0] e_npc;

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    check(!busy && !wr_en && !done && !overflow, "R12 idle outputs",
          {busy, wr_en, done, overflow}, 0);
    check(pc_out == 0 && next_pc == 0, "R12 pc zero", pc_out, 0);
    check(ne_flags == 0, "R12 ne_flags", ne_flags, 0);

    // R1 non-excepting flags set then cleared by packet start
    @(negedge clk); ne_set = 2'b01;
    @(negedge clk); ne_set = 2'b00;
    check(ne_flags == 2'b01, "R1 ne set", ne_flags, 1);
    do_pkt(32'h0000_2000);
    check(ne_flags == 2'b00, "R1 ne cleared", ne_flags, 0);
    check(pc_out == 32'h2000, "R1 pc latched", pc_out, 32'h2000);

    // main sweep: kinds x force x exception mode
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 64; k++) begin
        for (int f = 0; f < 8; f++) begin
          logic [AW-1:0] pp;
          logic taken;
          string rq;
          pp = 32'h0001_0000 + 32'(m * 1024 + k * 8 + f) * 4;
          xa[0] = 32'h100; xa[1] = 32'h100; xa[2] = 32'h104;
          for (int i = 0; i < 3; i++) begin
            xk[i] = 2'((k >> (2 * i)) & 3);
            xf[i] = f[i];
            xv[i] = {8'(m), 8'(k), 8'(f), 8'(i + 1)};
          end
          do_pkt(pp);
          for (int i = 0; i < 3; i++) enq(xa[i], xk[i], xf[i], DW'(i + 1), xv[i]);
          if (m == 1) set_exc(32'h100, 1'b1, 6'b000101);
          if (m == 2) set_exc(32'h100, 1'b1, 6'b010001);
          if (m == 3) set_exc(32'h100, 1'b0, 6'b000000);
          en = 0; taken = 0; e_npc = pp;
          for (int i = 0; i < 3; i++) begin
            logic keep;
            keep = 1;
            if (m != 0 && xa[i] == 32'h100) keep = (m == 1) ? 1'b1 : (m == 2) ? 1'b0 : xf[i];
            if (keep) begin
              if (xk[i] == 2'd1 || xk[i] == 2'd2) begin
                if (!taken) begin taken = 1; e_npc = xv[i]; end
              end else begin
                e_dest[en] = DW'(i + 1); e_data[en] = xv[i]; e_pc[en] = xa[i]; en++;
              end
            end
          end
          rq = (m == 0) ? "R4" : (m == 1) ? "R6" : (m == 2) ? "R7" : "R8";
          run_commit();
          check(nw == en, {rq, " write count"}, 64'(nw), 64'(en));
          for (int i = 0; i < en && i < nw; i++) begin
            check(o_dest[i] == e_dest[i] && o_data[i] == e_data[i], "R2 order",
                  {o_dest[i], o_data[i]}, {e_dest[i], e_data[i]});
            check(o_pc[i] == e_pc[i], "R3 reported pc", o_pc[i], e_pc[i]);
          end
          check(o_npc == e_npc && o_pcout == e_npc, "R5 next pc", o_npc, e_npc);
        end
      end
    end

    // R11 overflow with full queue
    do_pkt(32'h0000_5000);
    for (int i = 0; i < DEPTH; i++) begin
      enq(32'h200 + 32'(i), 2'd0, 1'b0, DW'(i), XW'(i));
      check(!overflow, "R11 no overflow below full", 64'(overflow), 0);
    end
    enq(32'h300, 2'd0, 1'b0, DW'(63), XW'(32'hDEAD));
    check(overflow, "R11 overflow pulse", 64'(overflow), 1);
    @(negedge clk);
    check(!overflow, "R11 overflow one cycle", 64'(overflow), 0);
    run_commit();
    check(nw == DEPTH, "R11 kept entries", 64'(nw), 64'(DEPTH));
    check(o_data[DEPTH-1] == XW'(DEPTH - 1), "R11 dropped entry", o_data[DEPTH-1], DEPTH - 1);

    // R10 second commit is empty
    run_commit();
    check(nw == 0, "R10 queue emptied", 64'(nw), 0);
    check(o_npc == 32'h5000, "R10 packet pc", o_npc, 32'h5000);

    // R9 link register update and clearing
    do_pkt(32'h0000_3000);
    @(negedge clk); link_req = 1;
    @(negedge clk); link_req = 0;
    enq(32'h3000, 2'd2, 1'b0, 6'd1, 32'h4444);
    run_commit();
    check(o_lrwe && o_lrd == 32'h3000, "R9 link write", o_lrd, 32'h3000);
    check(o_npc == 32'h4444, "R5 function pc write", o_npc, 32'h4444);
    run_commit();
    check(!o_lrwe, "R9 link flag cleared", 64'(o_lrwe), 0);

    // R1 packet start discards entries and exception record
    do_pkt(32'h0000_6000);
    enq(32'h500, 2'd0, 1'b0, 6'd7, 32'h77);
    enq(32'h500, 2'd0, 1'b0, 6'd8, 32'h88);
    set_exc(32'h500, 1'b0, '0);
    do_pkt(32'h0000_6100);
    enq(32'h500, 2'd0, 1'b0, 6'd9, 32'h99);
    run_commit();
    check(nw == 1, "R1 queue and exception cleared", 64'(nw), 1);
    check(nw > 0 && o_data[0] == 32'h99, "R1 surviving entry", o_data[0], 32'h99);
    check(o_npc == 32'h6100, "R1 new packet pc", o_npc, 32'h6100);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule